// File: doc/BRIEF.md
# Speculative Branch Predictor with Prediction History

This block sits in the fetch stage and answers one question per cycle: for the instruction at a given PC, is it taken, and what is the next PC? It consults a table of 2-bit saturating direction counters, a tagged target buffer, and a circular return stack. Each accepted prediction is recorded, together with its sequence number, in an in-order history queue.

Later pipeline stages drive a single command port. A commit retires the oldest records and trains the direction counters with the recorded outcome. A squash discards the youngest records and undoes the return-stack changes they made, one record at a time. A mispredict runs the same squash, then corrects the youngest surviving record, trains its counter and writes the corrected target into the buffer. The counters never change at prediction time.

A command runs over several cycles, one history record per cycle. While it runs, and in any cycle where a command is offered, predictions are held off.

Top module: `bpred_hist_unit`

## Requirements
- R1: After reset, `predReady` and `cmdReady` are high, the history and target buffer are empty, and every direction counter holds 1, so a conditional branch predicts not-taken.
- R2: A non-return prediction with `predUncond=1` is taken when the target buffer hits, and `predNextPc` is the stored target. The buffer index is PC bits [INST_SHIFT+BTB_IDX_W-1:INST_SHIFT], and the tag is the PC bits above the index.
- R3: A return (`predRet=1`) whose direction is taken (unconditional, or counter upper bit set) gives the return-stack top as `predNextPc` and pops the stack. Its record keeps the stack index and value as they were before the pop.
- R4: A non-return whose direction is taken but misses in the target buffer (invalid entry or tag mismatch) is reported not-taken.
- R5: A not-taken prediction gives `predNextPc = predPc + 2**INST_SHIFT`. A non-return call (`predCall=1`) whose direction is taken pushes `predPc + 2**INST_SHIFT` on the return stack, whether or not the target buffer hits.
- R6: Direction counters are 2 bits wide and saturate at 0 and 3. The upper bit means taken. The counter index is PC bits [INST_SHIFT+CTR_IDX_W-1:INST_SHIFT]. Counters are not changed by predictions.
- R7: Commit (`cmdOp=2'b01`, sequence N) removes records from the old end while their sequence number is at most N, oldest first. Each removed record trains its counter with its recorded direction. For an unconditional branch the recorded direction is taken, even if a buffer miss made the reported result not-taken.
- R8: Squash (`cmdOp=2'b10`, sequence N) removes records from the young end while their sequence number exceeds N, youngest first. A removed record that used the stack restores the saved index and value. A removed call record pops the stack.
- R9: Mispredict (`cmdOp=2'b11`, sequence N) first squashes as in R8. It then sets the youngest remaining record's direction to `cmdTaken`, trains that record's counter with `cmdTaken`, and writes `cmdTarget` into the target buffer entry for that record's PC.
- R10: The history holds HIST_DEPTH records. When it is full, `predReady` is low.
- R11: A command is accepted when `cmdValid` and `cmdReady` are both high. After acceptance `cmdReady` stays low while the command runs, one cycle per removed record. Whenever `cmdValid` is high, `predReady` is low, so a command wins over a prediction in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| predValid | input | 1 | Prediction request |
| predReady | output | 1 | Prediction accepted this cycle when high with predValid |
| predPc | input | PC_W | PC of the instruction |
| predSeq | input | SEQ_W | Sequence number of the instruction |
| predUncond | input | 1 | Unconditional control transfer |
| predCall | input | 1 | Call instruction |
| predRet | input | 1 | Return instruction |
| predTaken | output | 1 | Predicted taken |
| predNextPc | output | PC_W | Predicted next PC |
| cmdValid | input | 1 | Command request |
| cmdReady | output | 1 | Command port idle |
| cmdOp | input | 2 | 01 commit, 10 squash, 11 mispredict |
| cmdSeq | input | SEQ_W | Sequence bound N of the command |
| cmdTaken | input | 1 | Actual direction for a mispredict |
| cmdTarget | input | PC_W | Corrected target for a mispredict |

## Verification
The prediction port and the command port can both be offered in the same cycle. The bench provokes this by raising `predValid` and a commit in the same cycle while the history holds several records. It expects `predReady` to be low and `cmdReady` to be high in that cycle, and `cmdReady` to be low in the following cycle. The prediction must then be accepted only after the commit finishes, with the correct result. The bench also checks that the return stack is rebuilt correctly when a squash removes a return and a call that were predicted back to back, and that counters trained across a commit saturate instead of wrapping.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

  typedef enum logic [1:0] {
    OP_NONE    = 2'b00,
    OP_COMMIT  = 2'b01,
    OP_SQUASH  = 2'b10,
    OP_MISPRED = 2'b11
  } cmdOp_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RETIRE,
    ST_DROP,
    ST_FIX
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic predAccept;
    logic cmdLatch;
    logic retireOld;
    logic dropYoung;
    logic fixYoung;
  } dpStrobe_t;

endpackage

// File: rtl/bpred_ctr_table.sv
module bpred_ctr_table #(
  parameter int CTR_IDX_W = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CTR_IDX_W-1:0] rdIdx,
  output logic                 rdTaken,
  input  logic                 updEn,
  input  logic [CTR_IDX_W-1:0] updIdx,
  input  logic                 updTaken
);
  localparam int CTR_N = 1 << CTR_IDX_W;

  logic [1:0] ctrVal [CTR_N];

  for (genvar i = 0; i < CTR_N; i++) begin : g_ctr
    logic [1:0] cntQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntQ <= 2'b01;
      end else if (updEn && updIdx == CTR_IDX_W'(i)) begin
        if (updTaken) begin
          if (cntQ != 2'b11) cntQ <= cntQ + 2'b01;
        end else begin
          if (cntQ != 2'b00) cntQ <= cntQ - 2'b01;
        end
      end
    end
    assign ctrVal[i] = cntQ;
  end

  assign rdTaken = ctrVal[rdIdx][1];

endmodule

// File: rtl/bpred_ras.sv
module bpred_ras #(
  parameter int PC_W      = 32,
  parameter int RAS_IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pushEn,
  input  logic [PC_W-1:0]      pushVal,
  input  logic                 popEn,
  input  logic                 restoreEn,
  input  logic [RAS_IDX_W-1:0] restoreIdx,
  input  logic [PC_W-1:0]      restoreVal,
  output logic [RAS_IDX_W-1:0] topIdx,
  output logic [PC_W-1:0]      topVal
);
  localparam int RAS_N = 1 << RAS_IDX_W;

  logic [PC_W-1:0]      stackQ [RAS_N];
  logic [RAS_IDX_W-1:0] ptrQ;
  logic [RAS_IDX_W-1:0] ptrUp;
  logic [RAS_IDX_W-1:0] ptrDown;

  assign ptrUp   = ptrQ + RAS_IDX_W'(1);
  assign ptrDown = ptrQ - RAS_IDX_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
      for (int i = 0; i < RAS_N; i++) stackQ[i] <= '0;
    end else if (restoreEn) begin
      ptrQ               <= restoreIdx;
      stackQ[restoreIdx] <= restoreVal;
    end else if (pushEn) begin
      ptrQ          <= ptrUp;
      stackQ[ptrUp] <= pushVal;
    end else if (popEn) begin
      ptrQ <= ptrDown;
    end
  end

  assign topIdx = ptrQ;
  assign topVal = stackQ[ptrQ];

endmodule

// File: rtl/bpred_ctrl.sv
module bpred_ctrl
  import bpred_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      predValid,
  input  logic      cmdValid,
  input  logic [1:0] cmdOp,
  input  logic      histFull,
  input  logic      histEmpty,
  input  logic      oldestDone,
  input  logic      youngestWrong,
  output logic      predReady,
  output logic      cmdReady,
  output dpStrobe_t stb
);
  ctrlState_e stateQ, stateD;
  cmdOp_e     opQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      opQ    <= OP_NONE;
    end else begin
      stateQ <= stateD;
      if (stb.cmdLatch) opQ <= cmdOp_e'(cmdOp);
    end
  end

  always_comb begin
    stb       = '0;
    stateD    = stateQ;
    cmdReady  = (stateQ == ST_IDLE);
    predReady = (stateQ == ST_IDLE) && !cmdValid && !histFull;
    unique case (stateQ)
      ST_IDLE: begin
        if (cmdValid) begin
          stb.cmdLatch = 1'b1;
          unique case (cmdOp_e'(cmdOp))
            OP_COMMIT:             stateD = ST_RETIRE;
            OP_SQUASH, OP_MISPRED: stateD = ST_DROP;
            default:               stateD = ST_IDLE;
          endcase
        end else if (predValid && predReady) begin
          stb.predAccept = 1'b1;
        end
      end
      ST_RETIRE: begin
        if (!histEmpty && oldestDone) stb.retireOld = 1'b1;
        else                          stateD = ST_IDLE;
      end
      ST_DROP: begin
        if (!histEmpty && youngestWrong) stb.dropYoung = 1'b1;
        else if (opQ == OP_MISPRED)      stateD = ST_FIX;
        else                             stateD = ST_IDLE;
      end
      ST_FIX: begin
        stb.fixYoung = !histEmpty;
        stateD       = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/bpred_dpath.sv
module bpred_dpath
  import bpred_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int SEQ_W      = 16,
  parameter int CTR_IDX_W  = 6,
  parameter int BTB_IDX_W  = 4,
  parameter int RAS_IDX_W  = 3,
  parameter int HIST_DEPTH = 8,
  parameter int INST_SHIFT = 2,
  localparam int CNT_W     = $clog2(HIST_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [PC_W-1:0]  predPc,
  input  logic [SEQ_W-1:0] predSeq,
  input  logic             predUncond,
  input  logic             predCall,
  input  logic             predRet,
  output logic             predTaken,
  output logic [PC_W-1:0]  predNextPc,
  input  logic [SEQ_W-1:0] cmdSeq,
  input  logic             cmdTaken,
  input  logic [PC_W-1:0]  cmdTarget,
  output logic             histFull,
  output logic             histEmpty,
  output logic             oldestDone,
  output logic             youngestWrong,
  output logic [CNT_W-1:0] histCount
);
  localparam int PTR_W  = $clog2(HIST_DEPTH);
  localparam int WPC_W  = PC_W - INST_SHIFT;
  localparam int TAG_W  = WPC_W - BTB_IDX_W;
  localparam int BTB_N  = 1 << BTB_IDX_W;
  localparam logic [PC_W-1:0] STEP = PC_W'(1) << INST_SHIFT;

  // latched command operands
  logic [SEQ_W-1:0] seqQ;
  logic             takenQ;
  logic [PC_W-1:0]  targetQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqQ    <= '0;
      takenQ  <= 1'b0;
      targetQ <= '0;
    end else if (stb.cmdLatch) begin
      seqQ    <= cmdSeq;
      takenQ  <= cmdTaken;
      targetQ <= cmdTarget;
    end
  end

  // history queue storage
  logic [SEQ_W-1:0]     hSeq    [HIST_DEPTH];
  logic [WPC_W-1:0]     hPc     [HIST_DEPTH];
  logic                 hTaken  [HIST_DEPTH];
  logic                 hUseRas [HIST_DEPTH];
  logic                 hCall   [HIST_DEPTH];
  logic [RAS_IDX_W-1:0] hRasIdx [HIST_DEPTH];
  logic [PC_W-1:0]      hRasVal [HIST_DEPTH];

  logic [PTR_W-1:0] headQ, tailQ, yIdx, headNext, tailNext;
  logic [CNT_W-1:0] cntQ;

  assign headNext = (headQ == PTR_W'(HIST_DEPTH - 1)) ? '0 : headQ + PTR_W'(1);
  assign tailNext = (tailQ == PTR_W'(HIST_DEPTH - 1)) ? '0 : tailQ + PTR_W'(1);
  assign yIdx     = (tailQ == '0) ? PTR_W'(HIST_DEPTH - 1) : tailQ - PTR_W'(1);

  assign histFull      = (cntQ == CNT_W'(HIST_DEPTH));
  assign histEmpty     = (cntQ == '0);
  assign histCount     = cntQ;
  assign oldestDone    = (hSeq[headQ] <= seqQ);
  assign youngestWrong = (hSeq[yIdx] > seqQ);

  // prediction lookup
  logic [WPC_W-1:0]     wordPc;
  logic                 ctrTaken, dirTaken, useRas, btbHit, finalTaken, pushCall;
  logic [BTB_IDX_W-1:0] btbRdIdx;
  logic [PC_W-1:0]      rasTop, seqPc, target;
  logic [RAS_IDX_W-1:0] rasTopIdx;

  logic                 btbValid [BTB_N];
  logic [TAG_W-1:0]     btbTag   [BTB_N];
  logic [PC_W-1:0]      btbTgt   [BTB_N];

  assign wordPc     = predPc[PC_W-1:INST_SHIFT];
  assign btbRdIdx   = wordPc[BTB_IDX_W-1:0];
  assign btbHit     = btbValid[btbRdIdx] && (btbTag[btbRdIdx] == wordPc[WPC_W-1 -: TAG_W]);
  assign dirTaken   = predUncond || ctrTaken;
  assign useRas     = dirTaken && predRet;
  assign pushCall   = dirTaken && predCall && !predRet;
  assign finalTaken = useRas || (dirTaken && !predRet && btbHit);
  assign seqPc      = predPc + STEP;
  assign target     = useRas ? rasTop : btbTgt[btbRdIdx];
  assign predTaken  = finalTaken;
  assign predNextPc = finalTaken ? target : seqPc;

  // history pointer and count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headQ <= '0;
      tailQ <= '0;
      cntQ  <= '0;
    end else if (stb.predAccept) begin
      tailQ <= tailNext;
      cntQ  <= cntQ + CNT_W'(1);
    end else if (stb.retireOld) begin
      headQ <= headNext;
      cntQ  <= cntQ - CNT_W'(1);
    end else if (stb.dropYoung) begin
      tailQ <= yIdx;
      cntQ  <= cntQ - CNT_W'(1);
    end
  end

  // history record contents
  always_ff @(posedge clk) begin
    if (stb.predAccept) begin
      hSeq[tailQ]    <= predSeq;
      hPc[tailQ]     <= wordPc;
      hTaken[tailQ]  <= dirTaken;
      hUseRas[tailQ] <= useRas;
      hCall[tailQ]   <= pushCall;
      hRasIdx[tailQ] <= rasTopIdx;
      hRasVal[tailQ] <= rasTop;
    end else if (stb.fixYoung) begin
      hTaken[yIdx] <= takenQ;
    end
  end

  // target buffer, written only on a mispredict fix
  logic [WPC_W-1:0]     fixPc;
  logic [BTB_IDX_W-1:0] btbWrIdx;

  assign fixPc    = hPc[yIdx];
  assign btbWrIdx = fixPc[BTB_IDX_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BTB_N; i++) begin
        btbValid[i] <= 1'b0;
        btbTag[i]   <= '0;
        btbTgt[i]   <= '0;
      end
    end else if (stb.fixYoung) begin
      btbValid[btbWrIdx] <= 1'b1;
      btbTag[btbWrIdx]   <= fixPc[WPC_W-1 -: TAG_W];
      btbTgt[btbWrIdx]   <= targetQ;
    end
  end

  // direction counters: trained by retire or fix only
  logic                 ctrUpdEn, ctrUpdTaken;
  logic [CTR_IDX_W-1:0] ctrUpdIdx;

  always_comb begin
    ctrUpdEn    = stb.retireOld || stb.fixYoung;
    ctrUpdIdx   = stb.retireOld ? hPc[headQ][CTR_IDX_W-1:0] : fixPc[CTR_IDX_W-1:0];
    ctrUpdTaken = stb.retireOld ? hTaken[headQ] : takenQ;
  end

  bpred_ctr_table #(.CTR_IDX_W(CTR_IDX_W)) ctr_i (
    .clk      (clk),
    .rstN     (rstN),
    .rdIdx    (wordPc[CTR_IDX_W-1:0]),
    .rdTaken  (ctrTaken),
    .updEn    (ctrUpdEn),
    .updIdx   (ctrUpdIdx),
    .updTaken (ctrUpdTaken)
  );

  // return stack with per-record repair
  logic rasPush, rasPop, rasRestore;

  assign rasPush    = stb.predAccept && pushCall;
  assign rasRestore = stb.dropYoung && hUseRas[yIdx];
  assign rasPop     = (stb.predAccept && useRas) ||
                      (stb.dropYoung && hCall[yIdx] && !hUseRas[yIdx]);

  bpred_ras #(.PC_W(PC_W), .RAS_IDX_W(RAS_IDX_W)) ras_i (
    .clk        (clk),
    .rstN       (rstN),
    .pushEn     (rasPush),
    .pushVal    (seqPc),
    .popEn      (rasPop),
    .restoreEn  (rasRestore),
    .restoreIdx (hRasIdx[yIdx]),
    .restoreVal (hRasVal[yIdx]),
    .topIdx     (rasTopIdx),
    .topVal     (rasTop)
  );

endmodule

// File: rtl/bpred_hist_unit.sv
module bpred_hist_unit
  import bpred_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int SEQ_W      = 16,
  parameter int CTR_IDX_W  = 6,
  parameter int BTB_IDX_W  = 4,
  parameter int RAS_IDX_W  = 3,
  parameter int HIST_DEPTH = 8,
  parameter int INST_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             predValid,
  output logic             predReady,
  input  logic [PC_W-1:0]  predPc,
  input  logic [SEQ_W-1:0] predSeq,
  input  logic             predUncond,
  input  logic             predCall,
  input  logic             predRet,
  output logic             predTaken,
  output logic [PC_W-1:0]  predNextPc,
  input  logic             cmdValid,
  output logic             cmdReady,
  input  logic [1:0]       cmdOp,
  input  logic [SEQ_W-1:0] cmdSeq,
  input  logic             cmdTaken,
  input  logic [PC_W-1:0]  cmdTarget
);
  localparam int CNT_W = $clog2(HIST_DEPTH + 1);

  dpStrobe_t        stb;
  logic             histFull, histEmpty, oldestDone, youngestWrong;
  logic [CNT_W-1:0] histCount;

  bpred_ctrl ctrl_i (
    .clk           (clk),
    .rstN          (rstN),
    .predValid     (predValid),
    .cmdValid      (cmdValid),
    .cmdOp         (cmdOp),
    .histFull      (histFull),
    .histEmpty     (histEmpty),
    .oldestDone    (oldestDone),
    .youngestWrong (youngestWrong),
    .predReady     (predReady),
    .cmdReady      (cmdReady),
    .stb           (stb)
  );

  bpred_dpath #(
    .PC_W(PC_W), .SEQ_W(SEQ_W), .CTR_IDX_W(CTR_IDX_W), .BTB_IDX_W(BTB_IDX_W),
    .RAS_IDX_W(RAS_IDX_W), .HIST_DEPTH(HIST_DEPTH), .INST_SHIFT(INST_SHIFT)
  ) dpath_i (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .predPc        (predPc),
    .predSeq       (predSeq),
    .predUncond    (predUncond),
    .predCall      (predCall),
    .predRet       (predRet),
    .predTaken     (predTaken),
    .predNextPc    (predNextPc),
    .cmdSeq        (cmdSeq),
    .cmdTaken      (cmdTaken),
    .cmdTarget     (cmdTarget),
    .histFull      (histFull),
    .histEmpty     (histEmpty),
    .oldestDone    (oldestDone),
    .youngestWrong (youngestWrong),
    .histCount     (histCount)
  );

endmodule

// File: rtl/bpred_hist_unit_chk.sv
module bpred_hist_unit_chk #(
  parameter int PC_W       = 32,
  parameter int HIST_DEPTH = 8,
  parameter int INST_SHIFT = 2,
  localparam int CNT_W     = $clog2(HIST_DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             predValid,
  input logic             predReady,
  input logic [PC_W-1:0]  predPc,
  input logic             predTaken,
  input logic [PC_W-1:0]  predNextPc,
  input logic             cmdValid,
  input logic             cmdReady,
  input logic [1:0]       cmdOp,
  input logic [CNT_W-1:0] histCount
);
  localparam logic [PC_W-1:0] STEP = PC_W'(1) << INST_SHIFT;

  assert_full_stall_R10: assert property (@(posedge clk) disable iff (!rstN)
    (histCount == CNT_W'(HIST_DEPTH)) |-> !predReady);

  assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    histCount <= CNT_W'(HIST_DEPTH));

  assert_seq_next_R5: assert property (@(posedge clk) disable iff (!rstN)
    (predValid && predReady && !predTaken) |-> (predNextPc == predPc + STEP));

  assert_cmd_wins_R11: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> !predReady);

  assert_cmd_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && cmdOp != 2'b00) |=> !cmdReady);

  assert_record_append_R7: assert property (@(posedge clk) disable iff (!rstN)
    (predValid && predReady) |=> (histCount == $past(histCount) + CNT_W'(1)));

endmodule

bind bpred_hist_unit bpred_hist_unit_chk #(
  .PC_W(PC_W), .HIST_DEPTH(HIST_DEPTH), .INST_SHIFT(INST_SHIFT)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .predValid  (predValid),
  .predReady  (predReady),
  .predPc     (predPc),
  .predTaken  (predTaken),
  .predNextPc (predNextPc),
  .cmdValid   (cmdValid),
  .cmdReady   (cmdReady),
  .cmdOp      (cmdOp),
  .histCount  (histCount)
);

// File: tb/bpred_hist_unit_tb_top.sv
module bpred_hist_unit_tb_top;
  localparam int PC_W  = 32;
  localparam int SEQ_W = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             predValid = 1'b0;
  logic             predReady;
  logic [PC_W-1:0]  predPc = '0;
  logic [SEQ_W-1:0] predSeq = '0;
  logic             predUncond = 1'b0;
  logic             predCall = 1'b0;
  logic             predRet = 1'b0;
  logic             predTaken;
  logic [PC_W-1:0]  predNextPc;
  logic             cmdValid = 1'b0;
  logic             cmdReady;
  logic [1:0]       cmdOp = 2'b00;
  logic [SEQ_W-1:0] cmdSeq = '0;
  logic             cmdTaken = 1'b0;
  logic [PC_W-1:0]  cmdTarget = '0;

  int unsigned checks = 0;
  int unsigned errors = 0;

  bit          expTakenQ[$];
  logic [31:0] expNextQ[$];
  string       expReqQ[$];
  event        sampleEv;

  always #5 clk = ~clk;

  bpred_hist_unit dut_i (
    .clk(clk), .rstN(rstN),
    .predValid(predValid), .predReady(predReady), .predPc(predPc), .predSeq(predSeq),
    .predUncond(predUncond), .predCall(predCall), .predRet(predRet),
    .predTaken(predTaken), .predNextPc(predNextPc),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp), .cmdSeq(cmdSeq),
    .cmdTaken(cmdTaken), .cmdTarget(cmdTarget)
  );

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic checkBit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", req, act, exp);
    end
  endtask

  // monitor: compares each accepted prediction with the scoreboard head
  always @(sampleEv) begin
    if (predValid && predReady) begin
      checks++;
      if (expReqQ.size() == 0) begin
        errors++;
        $display("FAIL unexpected prediction actual taken %0b next %h expected none",
                 predTaken, predNextPc);
      end else begin
        automatic bit    eT = expTakenQ.pop_front();
        automatic logic [31:0] eN = expNextQ.pop_front();
        automatic string eR = expReqQ.pop_front();
        if (predTaken !== eT || predNextPc !== eN) begin
          errors++;
          $display("FAIL %s actual taken %0b next %h expected taken %0b next %h",
                   eR, predTaken, predNextPc, eT, eN);
        end
      end
    end
  end

  task automatic waitPredAccept();
    bit done = 1'b0;
    while (!done) begin
      #2;
      ->sampleEv;
      if (predReady) done = 1'b1;
      else @(negedge clk);
    end
    @(posedge clk);
    #1 predValid = 1'b0;
  endtask

  task automatic doPred(logic [31:0] pc, int sq, bit u, bit c, bit r,
                        bit eT, logic [31:0] eN, string req);
    @(negedge clk);
    predPc = pc; predSeq = SEQ_W'(sq);
    predUncond = u; predCall = c; predRet = r; predValid = 1'b1;
    expTakenQ.push_back(eT); expNextQ.push_back(eN); expReqQ.push_back(req);
    waitPredAccept();
  endtask

  task automatic doCmd(logic [1:0] op, int sq, bit tk, logic [31:0] tgt);
    @(negedge clk);
    cmdOp = op; cmdSeq = SEQ_W'(sq); cmdTaken = tk; cmdTarget = tgt; cmdValid = 1'b1;
    while (!cmdReady) @(negedge clk);
    @(posedge clk);
    #1 cmdValid = 1'b0;
    @(negedge clk);
    while (!cmdReady) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual hung expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    checkBit("R1 predReady", predReady, 1'b1);
    checkBit("R1 cmdReady", cmdReady, 1'b1);

    // R1/R6: fresh counter predicts not-taken
    doPred(32'h1004, 1, 0, 0, 0, 1'b0, 32'h1008, "R1");
    // R4: unconditional with empty target buffer
    doPred(32'h1008, 2, 1, 0, 0, 1'b0, 32'h100c, "R4");
    // R9: fix record 2, buffer gets 0x2000, counter B goes to 2
    doCmd(2'b11, 2, 1'b1, 32'h2000);
    doPred(32'h1008, 3, 1, 0, 0, 1'b1, 32'h2000, "R2");
    doPred(32'h1008, 4, 0, 0, 0, 1'b1, 32'h2000, "R9 counter");
    // R9 with R8: drop 4,3,2 then fix record 1
    doCmd(2'b11, 1, 1'b1, 32'h3000);
    doPred(32'h1004, 2, 0, 0, 0, 1'b1, 32'h3000, "R9 target");
    // R6: counters untouched by predictions
    doPred(32'h100c, 3, 0, 0, 0, 1'b0, 32'h1010, "R5");
    doCmd(2'b11, 3, 1'b0, 32'h4000);
    doPred(32'h100c, 4, 1, 0, 0, 1'b1, 32'h4000, "R2");
    doPred(32'h100c, 5, 1, 0, 0, 1'b1, 32'h4000, "R2");
    doPred(32'h100c, 6, 0, 0, 0, 1'b0, 32'h1010, "R6 no speculative update");
    // R7: commit trains in order, saturating at 3
    doCmd(2'b01, 6, 1'b0, 32'h0);
    doPred(32'h1004, 7, 0, 0, 0, 1'b1, 32'h3000, "R7 saturate R6");
    doPred(32'h100c, 8, 0, 0, 0, 1'b0, 32'h1010, "R7 order");
    doCmd(2'b01, 8, 1'b0, 32'h0);

    // return stack: R5 push, R3 pop, R8 repair
    doPred(32'h1010, 10, 1, 1, 0, 1'b0, 32'h1014, "R5 call");
    doPred(32'h1014, 11, 1, 1, 0, 1'b0, 32'h1018, "R5 call");
    doPred(32'h1018, 12, 1, 0, 1, 1'b1, 32'h1018, "R3");
    doCmd(2'b10, 11, 1'b0, 32'h0);
    doPred(32'h101c, 12, 1, 0, 1, 1'b1, 32'h1018, "R8 restore");
    doCmd(2'b10, 10, 1'b0, 32'h0);
    doPred(32'h1020, 11, 1, 0, 1, 1'b1, 32'h1014, "R8 call pop");
    doCmd(2'b01, 11, 1'b0, 32'h0);

    // R10: fill the history
    for (int i = 0; i < 8; i++)
      doPred(32'h1040, 20 + i, 0, 0, 0, 1'b0, 32'h1044, "R10");
    @(negedge clk);
    #2 checkBit("R10 full stall", predReady, 1'b0);

    // R11: command and prediction offered together
    @(negedge clk);
    predPc = 32'h1040; predSeq = SEQ_W'(28);
    predUncond = 0; predCall = 0; predRet = 0;
    cmdOp = 2'b01; cmdSeq = SEQ_W'(21); cmdTaken = 0; cmdTarget = '0;
    predValid = 1'b1; cmdValid = 1'b1;
    expTakenQ.push_back(1'b0); expNextQ.push_back(32'h1044); expReqQ.push_back("R11 after commit");
    #2;
    checkBit("R11 predReady", predReady, 1'b0);
    checkBit("R11 cmdReady", cmdReady, 1'b1);
    @(posedge clk);
    #1 cmdValid = 1'b0;
    @(negedge clk);
    checkBit("R11 busy", cmdReady, 1'b0);
    waitPredAccept();

    doCmd(2'b01, 28, 1'b0, 32'h0);
    // R4: index hit but tag mismatch (index 1 holds 0x1004)
    doPred(32'h2004, 29, 1, 0, 0, 1'b0, 32'h2008, "R4 tag");
    doCmd(2'b01, 29, 1'b0, 32'h0);

    @(negedge clk);
    checks++;
    if (expReqQ.size() != 0) begin
      errors++;
      $display("FAIL R7 actual %0d pending expected 0", expReqQ.size());
    end
    summary();
    $finish;
  end

endmodule